// File: doc/BRIEF.md
# Conversion Offset Trim Unit

This unit removes a programmable offset from two streams of signed conversion results before they leave the converter core. The main lane carries 32-bit two's-complement samples and is trimmed by a 24-bit calibration word. The auxiliary lane carries 24-bit samples and is trimmed by a 16-bit word. In each lane the word is narrower than the sample. It is moved up so that its top bit lines up with the sample's top bit, giving a correction of word × 256, and then subtracted. A positive word therefore pulls the result down. A result that would leave the signed range is clamped to the nearest limit and does not wrap.

Host firmware loads the calibration words one byte at a time through a small register port, which has an address, write data and a write strobe. Any byte can be read back combinationally. When the chop input is high, both lanes run in pass mode and forward their samples unchanged. When it is low they run in trim mode. Each lane registers its result, so a corrected sample and its valid strobe appear one clock after the input sample.

Each lane selects between two named modes: TRIM (chop low: subtract the aligned word, then saturate) and PASS (chop high: forward the input). The choice is made again for every sample and takes effect immediately in either direction.

Top module: `offset_cal_unit`

## Requirements
- R1: While `rst_n` is low and after its release, every calibration byte reads 00h, both output data buses are zero and both output valid strobes are low.
- R2: A clock edge with `reg_wr` high stores `reg_wdata` into the byte at `reg_addr`. The main word's low, middle and high bytes are at 07h, 08h and 09h. The auxiliary word's low and high bytes are at 17h and 18h. `reg_rdata` returns the stored byte at the current `reg_addr`.
- R3: Reading any address other than 07h–09h and 17h–18h returns 00h. A write to such an address changes no stored byte.
- R4: In TRIM mode, a valid main sample x gives `main_dout` = x − s×256, where s is the sign-extended 24-bit word {09h,08h,07h}.
- R5: In TRIM mode, a valid auxiliary sample y gives `aux_dout` = y − t×256, where t is the sign-extended 16-bit word {18h,17h}.
- R6: A TRIM result above the signed maximum is output as 7FFFFFFFh on the main lane and 7FFFFFh on the auxiliary lane. A result below the signed minimum is output as 80000000h and 800000h respectively.
- R7: With `chop_en` high (PASS mode), each output equals its input sample whatever the stored words are.
- R8: Each output valid strobe equals its input valid strobe from the previous clock, in both modes. The output data changes only on a clock edge that follows a valid input, and holds otherwise.
- R9: A byte write takes effect for the first valid sample clocked at a later edge. A sample clocked on the same edge as the write still uses the old byte.
- R10: A zero word leaves samples unchanged. With a zero input on the main lane, word 000001h yields FFFFFF00h and word FFFFFFh yields 00000100h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Read-back byte at reg_addr |
| chop_en | input | 1 | High selects PASS mode on both lanes |
| main_din | input | 32 | Main-lane input sample |
| main_din_vld | input | 1 | Main-lane input valid |
| main_dout | output | 32 | Main-lane corrected sample |
| main_dout_vld | output | 1 | Main-lane output valid |
| aux_din | input | 24 | Auxiliary-lane input sample |
| aux_din_vld | input | 1 | Auxiliary-lane input valid |
| aux_dout | output | 24 | Auxiliary-lane corrected sample |
| aux_dout_vld | output | 1 | Auxiliary-lane output valid |

## Verification
The case hardest to reach from the ports is the edge where a byte write and a valid sample coincide. The sample must use the old word and the next sample must use the new one. The stimulus raises `reg_wr` and the valid strobe in the same cycle and follows at once with a second sample. Saturation needs the largest sample paired with the most negative word, and the reverse, so both limits are driven on purpose rather than left to random data.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
    typedef enum logic [0:0] {
        MODE_TRIM = 1'b0,
        MODE_PASS = 1'b1
    } lane_mode_e;

    localparam logic [7:0] MAIN_BASE  = 8'h07;
    localparam logic [7:0] AUX_BASE   = 8'h17;
    localparam int         MAIN_DW    = 32;
    localparam int         MAIN_CW    = 24;
    localparam int         AUX_DW     = 24;
    localparam int         AUX_CW     = 16;
endpackage

// File: rtl/ofc_regbank.sv
module ofc_regbank #(
    parameter int         NBYTES = 3,
    parameter logic [7:0] BASE   = 8'h07
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    input  logic                  wr,
    output logic [8*NBYTES-1:0]   word,
    output logic [7:0]            rdata
);
    localparam int WW = 8 * NBYTES;

    logic [7:0] bytes_q [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam logic [7:0] BYTE_ADDR = BASE + 8'(i);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[i] <= 8'h00;
            end else if (wr && (addr == BYTE_ADDR)) begin
                bytes_q[i] <= wdata;
            end
        end
        assign word[8*i +: 8] = bytes_q[i];
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NBYTES; k++) begin
            if (addr == BASE + 8'(k)) begin
                rdata = bytes_q[k];
            end
        end
    end

    logic [WW-1:0] unused_w;
    assign unused_w = word;
endmodule

// File: rtl/ofc_lane.sv
module ofc_lane
    import ofc_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chop,
    input  logic [DW-1:0] din,
    input  logic          din_vld,
    input  logic [CW-1:0] cal,
    output logic [DW-1:0] dout,
    output logic          dout_vld
);
    localparam int            SH     = DW - CW;
    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    lane_mode_e    mode;
    logic [DW:0]   ext_in;
    logic [DW:0]   ext_cal;
    logic [DW:0]   diff;
    logic [DW-1:0] trimmed;
    logic [DW-1:0] next_q;

    always_comb begin
        mode = chop ? MODE_PASS : MODE_TRIM;
    end

    always_comb begin
        ext_in  = {din[DW-1], din};
        ext_cal = {cal[CW-1], cal, {SH{1'b0}}};
        diff    = ext_in - ext_cal;
        unique case ({diff[DW], diff[DW-1]})
            2'b01:   trimmed = POS_LIM;
            2'b10:   trimmed = NEG_LIM;
            default: trimmed = diff[DW-1:0];
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_PASS: next_q = din;
            MODE_TRIM: next_q = trimmed;
            default:   next_q = din;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= din_vld;
            if (din_vld) begin
                dout <= next_q;
            end
        end
    end
endmodule

// File: rtl/offset_cal_unit.sv
module offset_cal_unit
    import ofc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    output logic [7:0]  reg_rdata,
    input  logic        chop_en,
    input  logic [31:0] main_din,
    input  logic        main_din_vld,
    output logic [31:0] main_dout,
    output logic        main_dout_vld,
    input  logic [23:0] aux_din,
    input  logic        aux_din_vld,
    output logic [23:0] aux_dout,
    output logic        aux_dout_vld
);
    localparam int MAIN_NB = MAIN_CW / 8;
    localparam int AUX_NB  = AUX_CW / 8;

    logic [MAIN_CW-1:0] main_cal;
    logic [AUX_CW-1:0]  aux_cal;
    logic [7:0]         main_rd;
    logic [7:0]         aux_rd;

    ofc_regbank #(.NBYTES(MAIN_NB), .BASE(MAIN_BASE)) u_main_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .wr    (reg_wr),
        .word  (main_cal),
        .rdata (main_rd)
    );

    ofc_regbank #(.NBYTES(AUX_NB), .BASE(AUX_BASE)) u_aux_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .wr    (reg_wr),
        .word  (aux_cal),
        .rdata (aux_rd)
    );

    assign reg_rdata = main_rd | aux_rd;

    ofc_lane #(.DW(MAIN_DW), .CW(MAIN_CW)) u_main_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .chop     (chop_en),
        .din      (main_din),
        .din_vld  (main_din_vld),
        .cal      (main_cal),
        .dout     (main_dout),
        .dout_vld (main_dout_vld)
    );

    ofc_lane #(.DW(AUX_DW), .CW(AUX_CW)) u_aux_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .chop     (chop_en),
        .din      (aux_din),
        .din_vld  (aux_din_vld),
        .cal      (aux_cal),
        .dout     (aux_dout),
        .dout_vld (aux_dout_vld)
    );
endmodule

// File: rtl/ofc_chk.sv
module ofc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  reg_addr,
    input logic [7:0]  reg_rdata,
    input logic        chop_en,
    input logic [31:0] main_din,
    input logic        main_din_vld,
    input logic [31:0] main_dout,
    input logic        main_dout_vld,
    input logic [23:0] aux_din,
    input logic        aux_din_vld,
    input logic [23:0] aux_dout,
    input logic        aux_dout_vld,
    input logic [23:0] main_cal
);
    logic mapped;
    assign mapped = (reg_addr == 8'h07) || (reg_addr == 8'h08) || (reg_addr == 8'h09)
                 || (reg_addr == 8'h17) || (reg_addr == 8'h18);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == 8'h00)); // R3

    AST_MAIN_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        main_dout_vld == $past(main_din_vld)); // R8

    AST_AUX_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        aux_dout_vld == $past(aux_din_vld)); // R8

    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !main_din_vld |=> $stable(main_dout)); // R8

    AST_MAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (main_din_vld && chop_en) |=> (main_dout == $past(main_din))); // R7

    AST_AUX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_din_vld && chop_en) |=> (aux_dout == $past(aux_din))); // R7

    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (main_din_vld && !chop_en && main_cal == 24'h0) |=> (main_dout == $past(main_din))); // R10

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (main_din_vld && !chop_en && !main_din[31] && main_cal[23]) |=> !main_dout[31]); // R6

    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (main_din_vld && !chop_en && main_din[31] && !main_cal[23] && main_cal != 24'h0)
            |=> main_dout[31]); // R6
endmodule

bind offset_cal_unit ofc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .chop_en       (chop_en),
    .main_din      (main_din),
    .main_din_vld  (main_din_vld),
    .main_dout     (main_dout),
    .main_dout_vld (main_dout_vld),
    .aux_din       (aux_din),
    .aux_din_vld   (aux_din_vld),
    .aux_dout      (aux_dout),
    .aux_dout_vld  (aux_dout_vld),
    .main_cal      (main_cal)
);

// File: tb/sim_offset_cal_unit.sv
`timescale 1ns/1ps
module sim_offset_cal_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_rdata;
    logic        chop_en = 1'b0;
    logic [31:0] main_din = '0;
    logic        main_din_vld = 1'b0;
    logic [31:0] main_dout;
    logic        main_dout_vld;
    logic [23:0] aux_din = '0;
    logic        aux_din_vld = 1'b0;
    logic [23:0] aux_dout;
    logic        aux_dout_vld;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    offset_cal_unit u0 (.*);

    // reference model state
    logic [7:0]  mb [3];
    logic [7:0]  ab [2];
    logic [31:0] e_main = '0;
    logic        e_mvld = 1'b0;
    logic [23:0] e_aux = '0;
    logic        e_avld = 1'b0;

    function automatic longint trim(longint x, longint c, int dw);
        longint d, mx, mn;
        d  = x - c * 256;
        mx = (64'sd1 <<< (dw - 1)) - 1;
        mn = -(64'sd1 <<< (dw - 1));
        if (d > mx) return mx;
        if (d < mn) return mn;
        return d;
    endfunction

    function automatic logic [7:0] model_rd(logic [7:0] a);
        case (a)
            8'h07: return mb[0];
            8'h08: return mb[1];
            8'h09: return mb[2];
            8'h17: return ab[0];
            8'h18: return ab[1];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) mb[i] <= 8'h00;
            for (int i = 0; i < 2; i++) ab[i] <= 8'h00;
            e_main <= '0; e_mvld <= 1'b0; e_aux <= '0; e_avld <= 1'b0;
        end else begin
            e_mvld <= main_din_vld;
            e_avld <= aux_din_vld;
            if (main_din_vld)
                e_main <= chop_en ? main_din :
                    32'(trim(longint'($signed(main_din)),
                             longint'($signed({mb[2], mb[1], mb[0]})), 32));
            if (aux_din_vld)
                e_aux <= chop_en ? aux_din :
                    24'(trim(longint'($signed(aux_din)),
                             longint'($signed({ab[1], ab[0]})), 24));
            if (reg_wr) begin
                case (reg_addr)
                    8'h07: mb[0] <= reg_wdata;
                    8'h08: mb[1] <= reg_wdata;
                    8'h09: mb[2] <= reg_wdata;
                    8'h17: ab[0] <= reg_wdata;
                    8'h18: ab[1] <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("main_dout_vld", 32'(main_dout_vld), 32'(e_mvld));
            chk("main_dout", main_dout, e_main);
            chk("aux_dout_vld", 32'(aux_dout_vld), 32'(e_avld));
            chk("aux_dout", 32'(aux_dout), 32'(e_aux));
            chk("reg_rdata", 32'(reg_rdata), 32'(model_rd(reg_addr)));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_byte(logic [7:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic set_main(logic [23:0] w);
        wr_byte(8'h07, w[7:0]); wr_byte(8'h08, w[15:8]); wr_byte(8'h09, w[23:16]);
    endtask

    task automatic set_aux(logic [15:0] w);
        wr_byte(8'h17, w[7:0]); wr_byte(8'h18, w[15:8]);
    endtask

    task automatic push(logic [31:0] m, logic [23:0] x);
        main_din = m; aux_din = x; main_din_vld = 1'b1; aux_din_vld = 1'b1;
        step();
        main_din_vld = 1'b0; aux_din_vld = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        cmp_on = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        foreach (mb[i]) begin reg_addr = 8'h07 + 8'(i); step(); end
        cur_req = "R2";
        set_main(24'hA5C3_1E);
        set_aux(16'h7E81);
        for (int a = 8'h06; a <= 8'h19; a++) begin reg_addr = 8'(a); step(); end
        cur_req = "R3";
        wr_byte(8'h0A, 8'hFF); wr_byte(8'h16, 8'hEE); wr_byte(8'h00, 8'h55);
        reg_addr = 8'h0A; step(); reg_addr = 8'h07; step(); reg_addr = 8'h17; step();
        cur_req = "R10";
        set_main(24'h000000); set_aux(16'h0000);
        push(32'h1234_5678, 24'h89AB_CD); push(32'h8000_0000, 24'h7FFFFF);
        set_main(24'h000001); push(32'h0, 24'h0);
        set_main(24'hFFFFFF); push(32'h0, 24'h0);
        cur_req = "R4";
        for (int i = 0; i < 40; i++) begin
            set_main(24'($urandom)); set_aux(16'($urandom));
            cur_req = (i % 2 == 0) ? "R4" : "R5";
            push($urandom, 24'($urandom));
        end
        cur_req = "R6";
        set_main(24'h800000); set_aux(16'h8000);
        push(32'h7FFF_FFFF, 24'h7FFFFF); push(32'h0000_0001, 24'h000001);
        set_main(24'h7FFFFF); set_aux(16'h7FFF);
        push(32'h8000_0000, 24'h800000); push(32'hFFFF_FFFF, 24'hFFFFFF);
        cur_req = "R7";
        chop_en = 1'b1;
        push(32'h8000_0000, 24'h800000); push(32'h7FFF_FFFF, 24'h123456);
        push(32'h0000_0000, 24'h000000);
        chop_en = 1'b0;
        push(32'h0000_0000, 24'h000000);
        cur_req = "R8";
        main_din = 32'hDEAD_BEEF; main_din_vld = 1'b1; step();
        main_din_vld = 1'b0; main_din = 32'h0BAD_F00D; repeat (3) step();
        aux_din = 24'h13579B; aux_din_vld = 1'b1; step();
        aux_din_vld = 1'b0; aux_din = 24'h2468AC; repeat (3) step();
        cur_req = "R9";
        set_main(24'h000010); set_aux(16'h0010);
        reg_addr = 8'h07; reg_wdata = 8'h20; reg_wr = 1'b1;
        main_din = 32'h0001_0000; main_din_vld = 1'b1; step();
        reg_wr = 1'b0;
        main_din = 32'h0001_0000; step();
        reg_addr = 8'h17; reg_wdata = 8'h40; reg_wr = 1'b1;
        aux_din = 24'h010000; aux_din_vld = 1'b1; main_din_vld = 1'b0; step();
        reg_wr = 1'b0; step();
        aux_din_vld = 1'b0; repeat (2) step();
        cur_req = "R1";
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; reg_addr = 8'h09; step(); reg_addr = 8'h18; step();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule